// File: doc/BRIEF.md
# Aging Register Replacement Selector

This block picks a frame to evict from a fixed pool of physical frames. It approximates least-recently-used order without timestamps. Each frame owns a short history word. A reference to a frame marks the most significant bit of its word. A periodic tick moves every word one place toward the least significant end, so older use counts for less and less. A frame that has been idle for as many ticks as the word is wide decays to zero.

When software or a miss handler asks for a victim, the block searches all history words for the smallest unsigned value and returns that frame's index one cycle later, together with a one-cycle valid pulse. The reference strobe is driven from the address-translation path on each hit. The tick comes from an external interval timer. Both the frame count and the history width are parameters; the defaults are 8 and 8.

Top module: `aging_victim_sel`

## Requirements
- R1: After synchronous active-low reset every history word is zero, `victim_valid` is 0 and `victim_idx` is 0, so the first request afterwards returns frame 0.
- R2: A cycle with `ref_valid` high sets bit AGE_BITS-1 (the most significant bit) of the history word of frame `ref_frame`. No other bit and no other frame changes.
- R3: A cycle with `tick` high shifts every history word right by one place. A zero enters the most significant bit and the least significant bit is lost, so AGE_BITS ticks with no references bring every word to zero.
- R4: When `tick` and `ref_valid` are high in the same cycle, the referenced frame is first shifted and its most significant bit is then set in the shifted value.
- R5: The reported victim is a frame whose history word, compared as an unsigned number, is not larger than that of any other frame.
- R6: When several frames share the smallest value, the lowest frame index is reported.
- R7: `victim_valid` is high in exactly the cycle after a cycle with `victim_req` high, and `victim_idx` carries the result in that same cycle.
- R8: A request is answered from the history words as they stand before any reference or tick that arrives in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_valid | input | 1 | Marks a reference to frame `ref_frame` in this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| tick | input | 1 | Interval strobe that ages all history words |
| victim_req | input | 1 | Asks for a replacement victim |
| victim_idx | output | IDX_W | Index of the chosen victim frame |
| victim_valid | output | 1 | One-cycle pulse marking `victim_idx` as valid |

## Verification
On every cycle the assertions check the update of each history word: a reference sets the top bit, a tick shifts, tick and reference together combine in the fixed order, and an idle frame holds its value. They also check that the valid pulse follows each request and that the reported index is a minimal and lowest-index frame of the words captured at the request. The reset values and the end-to-end results can only be seen in the bench's scenarios. These include tie breaking among untouched frames, the same-cycle order of tick and reference, a request that coincides with a reference to the current minimum, full decay to zero after repeated ticks, and a long pseudo-random mix compared against a reference model.

// File: rtl/aging_pkg.sv
// Package: shared defaults for the aging replacement selector.
// Assumes: consumers override these through module parameters when needed.
package aging_pkg;
    localparam int DEF_FRAMES   = 8;
    localparam int DEF_AGE_BITS = 8;
endpackage

// File: rtl/aging_cell.sv
// Module: history word for one frame.
// Each tick shifts the word right by one bit. A hit sets the top bit, and it
// does so after the shift, so a tick and a hit in the same cycle leave the top
// bit set on the shifted value.
// Assumes: hit is already qualified for this frame.
module aging_cell #(
    parameter int AGE_BITS = aging_pkg::DEF_AGE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                hit,
    output logic [AGE_BITS-1:0] age
);
    logic [AGE_BITS-1:0] age_nxt;

    // Next history value: shift on tick, then mark use.
    always_comb begin
        age_nxt = tick ? (age >> 1) : age;
        if (hit) begin
            age_nxt[AGE_BITS-1] = 1'b1;
        end
    end

    // History register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else begin
            age <= age_nxt;
        end
    end
endmodule

// File: rtl/aging_min_find.sv
// Module: combinational search for the frame with the smallest history word.
// The scan runs in ascending index order with a strict less-than compare, so
// on a tie the lowest index is kept.
// Assumes: ages_flat packs frame i at bits [i*AGE_BITS +: AGE_BITS].
module aging_min_find #(
    parameter int NUM_FRAMES = aging_pkg::DEF_FRAMES,
    parameter int AGE_BITS   = aging_pkg::DEF_AGE_BITS,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_FRAMES*AGE_BITS-1:0] ages_flat,
    output logic [IDX_W-1:0]               min_idx
);
    logic [AGE_BITS-1:0] best_val;

    // Linear minimum scan with lowest-index tie break.
    always_comb begin
        best_val = ages_flat[AGE_BITS-1:0];
        min_idx  = '0;
        for (int i = 1; i < NUM_FRAMES; i++) begin
            if (ages_flat[i*AGE_BITS +: AGE_BITS] < best_val) begin
                best_val = ages_flat[i*AGE_BITS +: AGE_BITS];
                min_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/aging_victim_sel.sv
// Module: top of the aging replacement selector.
// It decodes references into per-frame hits, holds one history word per frame
// and registers the result of the minimum search when a victim is requested.
// Assumes: ref_frame values of NUM_FRAMES or above match no frame.
// A request sees the words from before any same-cycle update.
module aging_victim_sel #(
    parameter int NUM_FRAMES = aging_pkg::DEF_FRAMES,
    parameter int AGE_BITS   = aging_pkg::DEF_AGE_BITS,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             tick,
    input  logic             victim_req,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_valid
);
    logic [NUM_FRAMES*AGE_BITS-1:0] ages_flat;
    logic [NUM_FRAMES-1:0]          hit_vec;
    logic [IDX_W-1:0]               min_idx;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        // Per-frame reference decode.
        assign hit_vec[g] = ref_valid && (ref_frame == IDX_W'(g));

        aging_cell #(.AGE_BITS(AGE_BITS)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .hit   (hit_vec[g]),
            .age   (ages_flat[g*AGE_BITS +: AGE_BITS])
        );
    end

    aging_min_find #(
        .NUM_FRAMES (NUM_FRAMES),
        .AGE_BITS   (AGE_BITS),
        .IDX_W      (IDX_W)
    ) u_min (
        .ages_flat (ages_flat),
        .min_idx   (min_idx)
    );

    // Victim output register: one-cycle valid pulse per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_idx   <= '0;
        end else begin
            victim_valid <= victim_req;
            if (victim_req) begin
                victim_idx <= min_idx;
            end
        end
    end
endmodule

// File: rtl/aging_victim_sel_chk.sv
// Module: property checker for aging_victim_sel, attached by bind.
// It watches the history words and the victim port.
// Assumes: the same packing of ages_flat as the top module.
module aging_victim_sel_chk #(
    parameter int NF = 8,
    parameter int W  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_valid,
    input logic [IW-1:0] ref_frame,
    input logic          tick,
    input logic          victim_req,
    input logic [IW-1:0] victim_idx,
    input logic          victim_valid,
    input logic [NF*W-1:0] ages_flat
);
    logic [NF*W-1:0] snap;
    logic            min_ok;
    logic            tie_ok;

    // Capture the history words seen by each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (victim_req) begin
            snap <= ages_flat;
        end
    end

    // Compare the reported frame against every captured word.
    always_comb begin
        min_ok = 1'b1;
        tie_ok = 1'b1;
        for (int j = 0; j < NF; j++) begin
            if (snap[j*W +: W] < snap[victim_idx*W +: W]) begin
                min_ok = 1'b0;
            end
            if ((IW'(j) < victim_idx) && (snap[j*W +: W] == snap[victim_idx*W +: W])) begin
                tie_ok = 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NF; g++) begin : g_chk
        AST_REF_SETS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_valid && ref_frame == IW'(g)) |=> ages_flat[g*W + W - 1]); // R2
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !(ref_valid && ref_frame == IW'(g))) |=> $stable(ages_flat[g*W +: W])); // R2
        AST_TICK_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !(ref_valid && ref_frame == IW'(g)))
            |=> ages_flat[g*W +: W] == ($past(ages_flat[g*W +: W]) >> 1)); // R3
        AST_TICK_THEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && ref_valid && ref_frame == IW'(g))
            |=> ages_flat[g*W +: W] == (($past(ages_flat[g*W +: W]) >> 1) | (W'(1) << (W - 1)))); // R4
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req |=> victim_valid); // R7
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_req |=> !victim_valid); // R7
    AST_VICTIM_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> min_ok); // R5
    AST_VICTIM_LOWEST_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> tie_ok); // R6
endmodule

bind aging_victim_sel aging_victim_sel_chk #(
    .NF (NUM_FRAMES),
    .W  (AGE_BITS),
    .IW (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .ref_frame    (ref_frame),
    .tick         (tick),
    .victim_req   (victim_req),
    .victim_idx   (victim_idx),
    .victim_valid (victim_valid),
    .ages_flat    (ages_flat)
);

// File: tb/aging_victim_sel_bench.sv
// Directed bench for aging_victim_sel with a behavioural model of the history words.
module aging_victim_sel_bench;
    localparam int NF = 8;
    localparam int W  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic          tick = 1'b0;
    logic          victim_req = 1'b0;
    logic [IW-1:0] victim_idx;
    logic          victim_valid;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model [NF];
    logic [15:0]  lfsr = 16'hACE1;

    aging_victim_sel #(.NUM_FRAMES(NF), .AGE_BITS(W)) u_aging_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_frame    (ref_frame),
        .tick         (tick),
        .victim_req   (victim_req),
        .victim_idx   (victim_idx),
        .victim_valid (victim_valid)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_min();
        int best = 0;
        for (int i = 1; i < NF; i++) begin
            if (model[i] < model[best]) best = i;
        end
        return best;
    endfunction

    // One cycle: inputs set at a falling edge, outputs checked at the next.
    task automatic step(input bit rv, input int fr, input bit tk, input bit rq, input string tag);
        int exp;
        ref_valid  = rv;
        ref_frame  = IW'(fr);
        tick       = tk;
        victim_req = rq;
        exp = model_min();
        for (int i = 0; i < NF; i++) begin
            if (tk) model[i] = model[i] >> 1;
            if (rv && fr == i) model[i][W-1] = 1'b1;
        end
        @(negedge clk);
        ref_valid = 1'b0; tick = 1'b0; victim_req = 1'b0;
        check(victim_valid == rq, {tag, " R7 valid"}, int'(victim_valid), int'(rq));
        if (rq) check(victim_idx == IW'(exp), {tag, " victim"}, int'(victim_idx), exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NF; i++) model[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(victim_valid == 1'b0, "R1 valid after reset", int'(victim_valid), 0);
        check(victim_idx == '0, "R1 index after reset", int'(victim_idx), 0);
        step(0, 0, 0, 1, "R1 first request");
    endtask

    task automatic t_ties();
        step(1, 3, 0, 0, "R6 ref");
        step(0, 0, 0, 1, "R6 untouched frames tie");
        step(1, 0, 0, 0, "R6 ref");
        step(0, 0, 0, 1, "R6 next lowest");
    endtask

    task automatic t_single_gap();
        for (int i = 0; i < NF; i++) if (i != 5) step(1, i, 0, 0, "R2 ref");
        step(0, 0, 0, 1, "R2 R5 only unreferenced frame");
        step(0, 0, 1, 0, "R3 tick");
        step(1, 5, 0, 0, "R2 ref");
        step(0, 0, 0, 1, "R3 R5 older reference loses");
    endtask

    task automatic t_decay();
        for (int k = 0; k < W; k++) step(0, 0, 1, 0, "R3 tick");
        step(0, 0, 0, 1, "R3 full decay ties at zero");
    endtask

    task automatic t_order();
        for (int i = 0; i < NF; i++) if (i != 2 && i != 6) step(1, i, 0, 0, "R4 setup");
        step(1, 6, 0, 0, "R4 ref before tick");
        step(1, 2, 1, 0, "R4 tick with ref");
        for (int i = 0; i < NF; i++) if (i != 2 && i != 6) step(1, i, 0, 0, "R4 refresh");
        step(0, 0, 0, 1, "R4 shift before set");
    endtask

    task automatic t_same_cycle_req();
        int m;
        m = model_min();
        step(1, m, 0, 1, "R8 request with ref");
        step(0, 0, 0, 1, "R8 following request");
        step(0, 0, 1, 1, "R8 request with tick");
        step(0, 0, 0, 1, "R7 back to back");
        step(0, 0, 0, 0, "R7 idle");
    endtask

    task automatic t_random();
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], int'(lfsr[3:1]), lfsr[6] & lfsr[7], lfsr[9] & lfsr[10], "R5 random mix");
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ties();
        t_single_gap();
        t_decay();
        t_order();
        t_same_cycle_req();
        t_random();
        t_decay();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule